// File: doc/BRIEF.md
# ADC Serial Output Port Model

This block reproduces, on the device side, the digital serial port of a successive-approximation converter running in 3-wire chip-select mode. A host drives a convert strobe, a serial clock and a mode pin. The block answers on a serial data line with an output enable that stands in for tri-state. A rising convert strobe with the mode pin high starts a conversion. The conversion lasts a fixed number of system clocks and cannot be interrupted. When the conversion ends, the word on a parallel sample input is captured as the result.

After the conversion, a low convert strobe puts the most significant result bit on the data line. Each later falling serial clock edge moves the line to the next lower bit. The line goes quiet after the last bit, or earlier if the strobe rises again. A rise of the mode pin alone, with the strobe not rising, starts nothing; this is how the other serial modes are recognised and left unsupported.

The host inputs are taken as synchronous to the system clock. Each host edge is seen at the first system clock edge that samples the new level. Outputs are registered.

Top module: `adc_serial_port`

## Requirements
- R1: After reset, `sdo_oe`, `sdo` and `busy` are all 0.
- R2: A clock edge that sees `cnv` high after it was low, with `sdi` high and `busy` low, starts a conversion. `busy` is 1 from the next cycle for exactly `CONV_CYCLES` cycles.
- R3: A `cnv` rise seen while `sdi` is low starts no conversion, and `busy` stays 0.
- R4: While `busy` is 1, `cnv` toggling, including a further rise, neither shortens nor restarts the conversion.
- R5: The result is the value of `sample` at the clock edge where `busy` falls. Later changes of `sample` do not alter the frame.
- R6: If `cnv` is low at the edge where `busy` falls, `sdo_oe` rises at that same edge and `sdo` carries result bit WIDTH-1.
- R7: If `cnv` is high when `busy` falls, `sdo_oe` stays 0 until the first edge that samples `cnv` low. At that edge `sdo_oe` becomes 1 with the MSB on `sdo`.
- R8: The serial word is sent MSB first. A clock edge that sees `sck` low after it was high, while enabled, advances `sdo` to the next lower bit from that edge. With no such fall, `sdo` holds.
- R9: The WIDTH-th falling `sck` edge of a frame clears `sdo_oe`. Further `sck` falls and `cnv` lows keep it 0 until the next conversion completes.
- R10: A `cnv` rise clears `sdo_oe` at the edge that sees it. This takes priority over an `sck` fall seen in the same cycle. If `sdi` is high and no conversion is running, the same rise also starts a new conversion.
- R11: `sdo` is 0 whenever `sdo_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnv | input | 1 | Convert strobe and chip select from the host |
| sck | input | 1 | Serial clock from the host |
| sdi | input | 1 | Mode pin; must be high for chip-select mode |
| sample | input | WIDTH | Parallel value captured as the conversion result |
| sdo | output | 1 | Serial data, valid while `sdo_oe` is 1 |
| sdo_oe | output | 1 | Output enable; 0 means high impedance |
| busy | output | 1 | Conversion in progress |

## Verification
Two collisions matter. The first is a strobe rise landing on the very clock edge where the conversion finishes. The bench counts cycles from the start edge and raises `cnv` for that exact edge. It expects the output to stay quiet, the busy line to fall, no new conversion to start, and the result to appear only once `cnv` goes low. The second is a strobe rise in the same cycle as a serial clock fall in the middle of a frame. There the bench expects the enable to drop with no bit advance. A behavioural model runs alongside and compares `sdo`, `sdo_oe` and `busy` on every clock.

// File: rtl/adcsp_pkg.sv
package adcsp_pkg;

   // width of a down-counter that must hold values up to n-1
   function automatic int cnt_bits(input int n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

   // status of the conversion engine as seen by the port control
   typedef struct packed {
      logic start;
      logic done;
      logic busy;
   } conv_stat_t;

endpackage

// File: rtl/adcsp_edge.sv
module adcsp_edge #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] din,
   output logic [N-1:0] rise,
   output logic [N-1:0] fall
);

   logic [N-1:0] prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= din;
   end

   for (genvar gi = 0; gi < N; gi++) begin : g_bit
      assign rise[gi] =  din[gi] & ~prev_q[gi];
      assign fall[gi] = ~din[gi] &  prev_q[gi];
   end

endmodule

// File: rtl/adcsp_conv_timer.sv
module adcsp_conv_timer #(
   parameter int CONV_CYCLES = 40
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic done
);

   localparam int CW = adcsp_pkg::cnt_bits(CONV_CYCLES);

   logic busy_q;

   if (CONV_CYCLES < 1) begin : g_bad
      $error("adcsp_conv_timer: CONV_CYCLES must be at least 1");
   end

   if (CONV_CYCLES == 1) begin : g_single
      always_ff @(posedge clk) begin
         if (!rst_n)      busy_q <= 1'b0;
         else if (busy_q) busy_q <= 1'b0;
         else             busy_q <= start;
      end
      assign done = busy_q;
   end else begin : g_count
      logic [CW-1:0] left_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            busy_q <= 1'b0;
            left_q <= '0;
         end else if (busy_q) begin
            if (left_q == '0) busy_q <= 1'b0;
            else              left_q <= left_q - 1'b1;
         end else if (start) begin
            busy_q <= 1'b1;
            left_q <= CW'(CONV_CYCLES - 1);
         end
      end
      assign done = busy_q && (left_q == '0);
   end

   assign busy = busy_q;

   // R2
   start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start && !busy |=> busy);

   // R4
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !done |=> busy);

endmodule

// File: rtl/adcsp_shifter.sv
module adcsp_shifter #(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [WIDTH-1:0] data,
   input  logic             adv,
   output logic             msb,
   output logic             last
);

   localparam int EW = adcsp_pkg::cnt_bits(WIDTH);

   logic [WIDTH-1:0] word_q;
   logic [EW-1:0]    shifts_q;

   if (WIDTH < 2) begin : g_bad
      $error("adcsp_shifter: WIDTH must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word_q   <= '0;
         shifts_q <= '0;
      end else if (load) begin
         word_q   <= data;
         shifts_q <= '0;
      end else if (adv && !last) begin
         word_q   <= {word_q[WIDTH-2:0], 1'b0};
         shifts_q <= shifts_q + 1'b1;
      end
   end

   assign msb  = word_q[WIDTH-1];
   assign last = (shifts_q == EW'(WIDTH - 1));

   // R8
   shift_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      32'(shifts_q) < WIDTH);

endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port #(
   parameter int WIDTH       = 16,
   parameter int CONV_CYCLES = 40
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cnv,
   input  logic             sck,
   input  logic             sdi,
   input  logic [WIDTH-1:0] sample,
   output logic             sdo,
   output logic             sdo_oe,
   output logic             busy
);

   import adcsp_pkg::*;

   localparam int CNV_I = 0;
   localparam int SCK_I = 1;

   logic [1:0] ev_rise, ev_fall;
   conv_stat_t cs;
   logic       armed_q, oe_q;
   logic       sh_msb, sh_last, sh_adv;
   logic       cnv_rise, sck_fall;

   adcsp_edge #(.N(2)) i_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .din  ({sck, cnv}),
      .rise (ev_rise),
      .fall (ev_fall)
   );

   assign cnv_rise = ev_rise[CNV_I];
   assign sck_fall = ev_fall[SCK_I];
   assign cs.start = cnv_rise && sdi && !cs.busy;

   adcsp_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) i_timer (
      .clk  (clk),
      .rst_n(rst_n),
      .start(cs.start),
      .busy (cs.busy),
      .done (cs.done)
   );

   assign sh_adv = oe_q && sck_fall && !cnv_rise && !cs.done;

   adcsp_shifter #(.WIDTH(WIDTH)) i_shift (
      .clk  (clk),
      .rst_n(rst_n),
      .load (cs.done),
      .data (sample),
      .adv  (sh_adv),
      .msb  (sh_msb),
      .last (sh_last)
   );

   // output enable: completion first, then abort, then open, then frame end
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         oe_q    <= 1'b0;
      end else if (cs.done) begin
         armed_q <= 1'b1;
         oe_q    <= ~cnv;
      end else if (cnv_rise) begin
         armed_q <= 1'b0;
         oe_q    <= 1'b0;
      end else if (armed_q && !oe_q && !cnv) begin
         oe_q    <= 1'b1;
      end else if (oe_q && sck_fall && sh_last) begin
         armed_q <= 1'b0;
         oe_q    <= 1'b0;
      end
   end

   assign sdo_oe = oe_q;
   assign sdo    = oe_q & sh_msb;
   assign busy   = cs.busy;

   // R10
   rise_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnv_rise |=> !sdo_oe);

   // R3
   no_mode_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnv_rise && !sdi && !busy |=> !busy);

   // R6
   oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sdo_oe |-> !busy);

   // R8
   sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sdo_oe && !sck_fall && !cnv_rise |=> sdo_oe && $stable(sdo));

endmodule

// File: tb/test_adc_serial_port.sv
`timescale 1ns/1ps
module test_adc_serial_port;

   localparam int W    = 16;
   localparam int CONV = 12;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cnv = 1'b0, sck = 1'b0, sdi = 1'b1;
   logic [W-1:0] sample = '0;
   logic         sdo, sdo_oe, busy;

   int    total = 0;
   int    bad = 0;
   string cur_req = "R1";
   bit    done_flag = 1'b0;

   always #2.5 clk = ~clk;

   adc_serial_port #(.WIDTH(W), .CONV_CYCLES(CONV)) i_adc_serial_port (
      .clk(clk), .rst_n(rst_n), .cnv(cnv), .sck(sck), .sdi(sdi),
      .sample(sample), .sdo(sdo), .sdo_oe(sdo_oe), .busy(busy)
   );

   // behavioural reference model
   int         m_busy, m_left, m_armed, m_oe, m_idx, pc, ps;
   logic [W-1:0] m_word;

   always @(posedge clk) begin
      int rise, sfall, fin;
      if (!rst_n) begin
         m_busy = 0; m_left = 0; m_armed = 0; m_oe = 0; m_idx = 0;
         pc = 0; ps = 0; m_word = '0;
      end else begin
         rise  = (cnv && !pc) ? 1 : 0;
         sfall = (!sck && ps) ? 1 : 0;
         fin   = (m_busy != 0 && m_left == 1) ? 1 : 0;
         if (fin != 0) begin
            m_word = sample; m_idx = W - 1; m_armed = 1; m_oe = cnv ? 0 : 1;
         end else if (rise != 0) begin
            m_oe = 0; m_armed = 0;
         end else if (m_armed != 0 && m_oe == 0 && !cnv) begin
            m_oe = 1;
         end else if (m_oe != 0 && sfall != 0) begin
            if (m_idx == 0) begin m_oe = 0; m_armed = 0; end
            else m_idx = m_idx - 1;
         end
         if (m_busy != 0) begin
            if (m_left == 1) m_busy = 0;
            else m_left = m_left - 1;
         end else if (rise != 0 && sdi) begin
            m_busy = 1; m_left = CONV;
         end
         pc = cnv ? 1 : 0;
         ps = sck ? 1 : 0;
      end
   end

   task automatic check(input string req, input string what, input int got, input int exp);
      total++;
      if (got != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, got, exp, $time);
      end
   endtask

   // advance one clock, then compare against the model away from the edge
   task automatic step();
      int e_sdo;
      @(posedge clk);
      #1;
      e_sdo = (m_oe != 0) ? int'(m_word[m_idx]) : 0;
      check(cur_req, "model busy", int'(busy), m_busy);
      check(cur_req, "model sdo_oe", int'(sdo_oe), m_oe);
      check(cur_req, "model sdo (R11 when quiet)", int'(sdo), e_sdo);
   endtask

   task automatic sck_pulse();
      sck = 1'b1; step(); step();
      sck = 1'b0; step(); step();
   endtask

   initial begin
      #(200000 * 5);
      if (!done_flag) begin
         total++; bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int n;
      logic [W-1:0] pat;
      repeat (3) @(posedge clk);
      #1;
      // R1
      check("R1", "sdo_oe in reset", int'(sdo_oe), 0);
      check("R1", "busy in reset", int'(busy), 0);
      rst_n = 1'b1;
      step();
      check("R1", "sdo after reset", int'(sdo), 0);

      // R3: mode pin low, no conversion
      cur_req = "R3";
      sdi = 1'b0; cnv = 1'b1; step();
      check("R3", "busy after rise with sdi low", int'(busy), 0);
      step(); cnv = 1'b0; step(); step();
      check("R3", "still idle", int'(busy), 0);

      // R2/R4/R7/R5/R8/R9: full frame, cnv high at completion
      cur_req = "R2";
      sdi = 1'b1; pat = 16'hA5C3; sample = pat;
      cnv = 1'b1; step();
      n = 0;
      for (int i = 0; i < 40 && busy; i++) begin
         n++;
         if (i == 3) cnv = 1'b0;
         if (i == 5) cnv = 1'b1;
         step();
      end
      check("R2", "busy length with toggles (R4)", n, CONV);
      sample = 16'hFFFF;
      cur_req = "R7";
      step(); step();
      check("R7", "quiet while cnv high", int'(sdo_oe), 0);
      cnv = 1'b0; step();
      check("R7", "enable after cnv low", int'(sdo_oe), 1);
      check("R5", "MSB of latched word", int'(sdo), int'(pat[W-1]));
      cur_req = "R8";
      for (int b = W - 1; b >= 0; b--) begin
         check("R8", "frame bit", int'(sdo), int'(pat[b]));
         sck_pulse();
      end
      check("R9", "quiet after last fall", int'(sdo_oe), 0);
      cur_req = "R9";
      for (int k = 0; k < 3; k++) sck_pulse();
      check("R9", "quiet after extra sck", int'(sdo_oe), 0);
      cnv = 1'b1; step(); cnv = 1'b0; step(); step();
      check("R9", "quiet after cnv low again", int'(sdo_oe), 0);

      // R6: cnv low at completion, then R10 abort on sck fall
      cur_req = "R6";
      pat = 16'h3C5A; sample = pat;
      cnv = 1'b1; step(); cnv = 1'b0;
      for (int i = 0; i < 40 && busy; i++) step();
      check("R6", "enable at completion edge", int'(sdo_oe), 1);
      check("R6", "MSB at completion edge", int'(sdo), int'(pat[W-1]));
      cur_req = "R8";
      for (int k = 0; k < 5; k++) sck_pulse();
      check("R8", "bit after five falls", int'(sdo), int'(pat[W-6]));
      cur_req = "R10";
      sck = 1'b1; step();
      sck = 1'b0; cnv = 1'b1; step();
      check("R10", "abort beats sck fall", int'(sdo_oe), 0);
      check("R10", "abort rise starts conversion", int'(busy), 1);

      // rise on the completion edge itself
      pat = 16'h9E17; sample = pat;
      cnv = 1'b0;
      for (int i = 0; i < CONV - 1; i++) step();
      cnv = 1'b1; step();
      check("R10", "quiet when rise meets completion", int'(sdo_oe), 0);
      check("R4", "no restart at completion edge", int'(busy), 0);
      cur_req = "R7";
      step();
      check("R7", "waits for cnv low", int'(sdo_oe), 0);
      cnv = 1'b0; step();
      check("R7", "enable after coincident case", int'(sdo_oe), 1);
      check("R5", "MSB after coincident case", int'(sdo), int'(pat[W-1]));
      step(); step();

      done_flag = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule